// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers the interrupt sources of a small processor core. Every source has a pending flag, an enable bit and a priority bit. The block raises a single request toward the core and presents the vector address that the core should branch to. The core accepts the request with a take strobe, and it signals the end of a handler with a return strobe. The controller keeps the global enable bits itself. It clears the proper one when a request is taken and sets it again on return.

A control bit selects between two modes. In single-level mode, one global bit gates every source, and a second bit additionally gates the peripheral-class sources. All vectors go to 0x000008 in this mode. In two-level mode, each source's priority bit picks the high level (vector 0x000008) or the low level (vector 0x000018), and each level has its own global bit. A small state register records idle, in-low, in-high and in-high-over-low. With it, a high handler may preempt a low one but never the reverse, and returning from a preempting high handler resumes the low level.

Software reaches the flag, enable, priority and control words through a simple register port. Writes take effect at the next clock edge, and reads are combinational.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the flag, enable and priority words are zero, the control word is zero (single-level mode, both global bits clear), and irq_req is low.
- R2: A source's flag is set at the clock edge after its event pulse, whatever its enable or any global bit. A write to the flag word (address 0) replaces the flags, and an event in the same cycle as that write still sets its flag.
- R3: In single-level mode (control bit 2 = 0), irq_req is high when control bit 0 is set and some source has both flag and enable set. Sources with index NUM_CORE_SRC and above also need control bit 1. The vector is 0x000008, and priority bits have no effect.
- R4: In single-level mode, an accepted request (irq_take while irq_req is high) clears control bit 0. A return strobe sets it again, so a flag still set causes an immediate new request.
- R5: In two-level mode (control bit 2 = 1), a source with priority bit 1 requests vector 0x000008 and a source with priority bit 0 requests vector 0x000018. When both levels may be requested, the high level wins.
- R6: In two-level mode, control bit 0 enables the high-priority sources and control bit 1 enables the low-priority sources.
- R7: In two-level mode, taking a high request clears control bit 0 and taking a low request clears control bit 1. A high request is raised and taken while a low handler is active.
- R8: In two-level mode, no low request is raised while a high handler is active, even with control bit 1 set.
- R9: In two-level mode, a return strobe sets the global bit of the level being exited. Returning from a high handler that preempted a low one goes back to the low handler, and low requests stay blocked until that handler also returns.
- R10: An event on an enabled, globally enabled source raises irq_req one clock edge after the event pulse, well inside three instruction cycles.
- R11: The register port reads the flags at address 0, the enables at address 1, the priorities at address 2, and the control word at address 3 with global-A in bit 0, global-B in bit 1 and mode in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NUM_SRC | One-cycle event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 flags, 1 enables, 2 priorities, 3 control |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data for reg_addr |
| irq_req | output | 1 | Interrupt request to the core |
| irq_hi | output | 1 | Request is at the high level (always 1 in single-level mode) |
| irq_vec | output | ADDR_W | Vector address for the current request |
| irq_take | input | 1 | Core accepts the current request |
| irq_ret | input | 1 | Return-from-interrupt strobe |

## Verification
The bench drives a low handler that a high request preempts, then unwinds both returns. A design that dropped the nested state would either re-enable the low level too early or lose the low handler entirely. It holds a low-priority source pending during a high handler while the low global bit is still set, which catches a design that gates the low level only by its enable bit. It writes the flag word in the same cycle as an event, to catch a write that silently drops a fresh event. It also leaves flags set across returns, to confirm the immediate re-entry that a design clearing flags on take would hide.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    LV_IDLE       = 2'd0,
    LV_LO         = 2'd1,
    LV_HI         = 2'd2,
    LV_HI_OVER_LO = 2'd3
  } lvl_state_e;

  localparam logic [1:0] RA_FLAG = 2'd0;
  localparam logic [1:0] RA_EN   = 2'd1;
  localparam logic [1:0] RA_PRIO = 2'd2;
  localparam logic [1:0] RA_CTRL = 2'd3;

  localparam int CB_GA   = 0;
  localparam int CB_GB   = 1;
  localparam int CB_MODE = 2;

  // Level state reached when a request is accepted.
  function automatic lvl_state_e st_after_take(input lvl_state_e s, input logic hi);
    if (!hi) return LV_LO;
    return (s == LV_LO) ? LV_HI_OVER_LO : LV_HI;
  endfunction

  // Level state reached on a return strobe.
  function automatic lvl_state_e st_after_ret(input lvl_state_e s);
    case (s)
      LV_HI_OVER_LO: return LV_LO;
      default:       return LV_IDLE;
    endcase
  endfunction

  // Whether the current state admits a request of the given level.
  function automatic logic level_admitted(input lvl_state_e s, input logic hi);
    if (hi) return (s == LV_IDLE) || (s == LV_LO);
    return s == LV_IDLE;
  endfunction

endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               wr_flag,
  input  logic               wr_en,
  input  logic               wr_prio,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] flag_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] prio_q
);
  logic [NUM_SRC-1:0] flag_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    // an event always wins over a clearing write
    assign flag_d[i] = (wr_flag ? wdata[i] : flag_q[i]) | src_evt[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_en)   en_q   <= wdata;
      if (wr_prio) prio_q <= wdata;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int              NUM_SRC      = 8,
  parameter int              NUM_CORE_SRC = 2,
  parameter int              ADDR_W       = 21,
  parameter logic [ADDR_W-1:0] VEC_HI     = 21'h000008,
  parameter logic [ADDR_W-1:0] VEC_LO     = 21'h000018
) (
  input  logic [NUM_SRC-1:0] flag,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] prio,
  input  logic               mode,
  input  logic               gbl_a,
  input  logic               gbl_b,
  input  lvl_state_e         state,
  output logic               req,
  output logic               hi,
  output logic [ADDR_W-1:0]  vec
);
  localparam logic [NUM_SRC-1:0] PERIPH_MASK = {NUM_SRC{1'b1}} << NUM_CORE_SRC;

  logic [NUM_SRC-1:0] armed;
  logic single_go, hi_go, lo_go;

  assign armed     = flag & en;
  assign single_go = gbl_a & ((|(armed & ~PERIPH_MASK)) | (gbl_b & (|(armed & PERIPH_MASK))));
  assign hi_go     = gbl_a & (|(armed & prio))  & level_admitted(state, 1'b1);
  assign lo_go     = gbl_b & (|(armed & ~prio)) & level_admitted(state, 1'b0);

  always_comb begin
    if (!mode) begin
      req = single_go;
      hi  = 1'b1;
    end else begin
      req = hi_go | lo_go;
      hi  = hi_go;
    end
    vec = hi ? VEC_HI : VEC_LO;
  end
endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm
  import irq_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [2:0] ctrl_wdata,
  input  logic       take_ok,
  input  logic       take_hi,
  input  logic       ret,
  output logic       mode,
  output logic       gbl_a,
  output logic       gbl_b,
  output lvl_state_e state
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= 1'b0;
      gbl_a <= 1'b0;
      gbl_b <= 1'b0;
      state <= LV_IDLE;
    end else begin
      if (wr_ctrl) begin
        mode  <= ctrl_wdata[CB_MODE];
        gbl_a <= ctrl_wdata[CB_GA];
        gbl_b <= ctrl_wdata[CB_GB];
      end
      if (take_ok) begin
        if (!mode || take_hi) gbl_a <= 1'b0;
        else                  gbl_b <= 1'b0;
        if (mode) state <= st_after_take(state, take_hi);
      end else if (ret) begin
        if (!mode) begin
          gbl_a <= 1'b1;
        end else begin
          case (state)
            LV_HI, LV_HI_OVER_LO: gbl_a <= 1'b1;
            LV_LO:                gbl_b <= 1'b1;
            default:              ;
          endcase
          state <= st_after_ret(state);
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int                NUM_SRC      = 8,
  parameter int                NUM_CORE_SRC = 2,
  parameter int                ADDR_W       = 21,
  parameter logic [ADDR_W-1:0] VEC_HI       = 21'h000008,
  parameter logic [ADDR_W-1:0] VEC_LO       = 21'h000018
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               irq_req,
  output logic               irq_hi,
  output logic [ADDR_W-1:0]  irq_vec,
  input  logic               irq_take,
  input  logic               irq_ret
);
  localparam int CTRL_W = 3;

  logic [NUM_SRC-1:0] flag_q, en_q, prio_q;
  logic               prio_mode, gbl_a, gbl_b;
  lvl_state_e         lvl_state;
  logic               wr_flag, wr_en, wr_prio, wr_ctrl;
  logic               take_ok;

  assign wr_flag = reg_we && (reg_addr == RA_FLAG);
  assign wr_en   = reg_we && (reg_addr == RA_EN);
  assign wr_prio = reg_we && (reg_addr == RA_PRIO);
  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign take_ok = irq_take && irq_req;

  irq_src_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .wr_flag(wr_flag), .wr_en(wr_en), .wr_prio(wr_prio), .wdata(reg_wdata),
    .flag_q(flag_q), .en_q(en_q), .prio_q(prio_q)
  );

  irq_arbiter #(
    .NUM_SRC(NUM_SRC), .NUM_CORE_SRC(NUM_CORE_SRC), .ADDR_W(ADDR_W),
    .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)
  ) u_arb (
    .flag(flag_q), .en(en_q), .prio(prio_q), .mode(prio_mode),
    .gbl_a(gbl_a), .gbl_b(gbl_b), .state(lvl_state),
    .req(irq_req), .hi(irq_hi), .vec(irq_vec)
  );

  irq_level_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .ctrl_wdata(reg_wdata[CTRL_W-1:0]),
    .take_ok(take_ok), .take_hi(irq_hi), .ret(irq_ret),
    .mode(prio_mode), .gbl_a(gbl_a), .gbl_b(gbl_b), .state(lvl_state)
  );

  always_comb begin
    case (reg_addr)
      RA_FLAG: reg_rdata = flag_q;
      RA_EN:   reg_rdata = en_q;
      RA_PRIO: reg_rdata = prio_q;
      default: reg_rdata = {{(NUM_SRC-CTRL_W){1'b0}}, prio_mode, gbl_b, gbl_a};
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int                NUM_SRC = 8,
  parameter int                ADDR_W  = 21,
  parameter logic [ADDR_W-1:0] VEC_HI  = 21'h000008,
  parameter logic [ADDR_W-1:0] VEC_LO  = 21'h000018
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_evt,
  input logic [NUM_SRC-1:0] flags,
  input logic               irq_req,
  input logic               irq_hi,
  input logic [ADDR_W-1:0]  irq_vec,
  input logic               irq_take,
  input logic               irq_ret,
  input logic               mode,
  input logic               gbl_a,
  input logic               gbl_b,
  input lvl_state_e         state
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((flags & $past(src_evt)) == $past(src_evt))); // R2
  AST_SINGLE_HIGH_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !mode) |-> (irq_hi && irq_vec == VEC_HI)); // R3
  AST_LOW_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_hi) |-> (irq_vec == VEC_LO)); // R5
  AST_TAKE_HI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_req && irq_hi) |=> !gbl_a); // R7
  AST_TAKE_LO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && irq_req && !irq_hi) |=> !gbl_b); // R7
  AST_NO_LOW_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LV_HI || state == LV_HI_OVER_LO) |-> !(irq_req && !irq_hi)); // R8
  AST_RET_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_take && mode && state == LV_HI_OVER_LO) |=> (state == LV_LO && gbl_a)); // R9
endmodule

bind irq_prio_ctrl irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .flags(flag_q),
  .irq_req(irq_req), .irq_hi(irq_hi), .irq_vec(irq_vec),
  .irq_take(irq_take), .irq_ret(irq_ret),
  .mode(prio_mode), .gbl_a(gbl_a), .gbl_b(gbl_b), .state(lvl_state)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int CLK_P  = 10;
  localparam int NSRC   = 8;
  localparam int AW     = 21;
  localparam logic [AW-1:0] V_HI = 21'h000008;
  localparam logic [AW-1:0] V_LO = 21'h000018;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_evt = '0;
  logic            reg_we = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic [NSRC-1:0] reg_wdata = '0;
  logic [NSRC-1:0] reg_rdata;
  logic            irq_req, irq_hi;
  logic [AW-1:0]   irq_vec;
  logic            irq_take = 1'b0;
  logic            irq_ret = 1'b0;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_hi(irq_hi), .irq_vec(irq_vec),
    .irq_take(irq_take), .irq_ret(irq_ret)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic            req;
    logic [AW-1:0]   vec;
    logic [NSRC-1:0] rd;
    string           tag;
  } exp_t;

  exp_t sb_q[$];
  event sample_ev;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // monitor: pops expected items and compares with the live outputs
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (irq_req !== e.req || (e.req && irq_vec !== e.vec) || reg_rdata !== e.rd) begin
          errors++;
          $display("FAIL %s: req=%0b vec=%h rd=%h expected req=%0b vec=%h rd=%h",
                   e.tag, irq_req, irq_vec, reg_rdata, e.req, e.vec, e.rd);
        end
      end
    end
  end

  task automatic expect_out(input logic req, input logic [AW-1:0] vec,
                            input logic [1:0] addr, input logic [NSRC-1:0] rd,
                            input string tag);
    exp_t e;
    reg_addr = addr;
    #1;
    e.req = req; e.vec = vec; e.rd = rd; e.tag = tag;
    sb_q.push_back(e);
    -> sample_ev;
    #1;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [NSRC-1:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_evt(input logic [NSRC-1:0] m);
    @(negedge clk); src_evt = m;
    @(negedge clk); src_evt = '0;
  endtask

  task automatic take();
    @(negedge clk); irq_take = 1'b1;
    @(negedge clk); irq_take = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_out(1'b0, V_HI, 2'd0, 8'h00, "R1 flags zero");
    expect_out(1'b0, V_HI, 2'd3, 8'h00, "R1 control zero");

    // R2 flags set regardless of enables; write replaces; event beats write
    pulse_evt(8'h05);
    expect_out(1'b0, V_HI, 2'd0, 8'h05, "R2 flag set while disabled");
    wr(2'd0, 8'h00);
    expect_out(1'b0, V_HI, 2'd0, 8'h00, "R2 flag write clears");
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; src_evt = 8'h10;
    @(negedge clk);
    reg_we = 1'b0; src_evt = '0;
    expect_out(1'b0, V_HI, 2'd0, 8'h10, "R2 event wins over write");

    // R10 latency, single mode
    wr(2'd1, 8'h01);
    wr(2'd3, 8'h01);
    expect_out(1'b0, V_HI, 2'd3, 8'h01, "R11 control readback");
    pulse_evt(8'h01);
    expect_out(1'b1, V_HI, 2'd1, 8'h01, "R10 request one edge after event");

    // R4 take clears global, return restores and re-enters
    take();
    expect_out(1'b0, V_HI, 2'd3, 8'h00, "R4 take clears global-A");
    ret();
    expect_out(1'b1, V_HI, 2'd3, 8'h01, "R4 return re-enters");

    // R3 peripheral gating, priority bits ignored
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h04);
    wr(2'd2, 8'h00);
    pulse_evt(8'h04);
    expect_out(1'b0, V_HI, 2'd0, 8'h04, "R3 peripheral gated by global-B");
    wr(2'd3, 8'h03);
    expect_out(1'b1, V_HI, 2'd3, 8'h03, "R3 single mode vector high despite prio 0");

    // two-level mode
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h05);
    wr(2'd1, 8'h0C);
    wr(2'd2, 8'h08);
    pulse_evt(8'h04);
    expect_out(1'b0, V_HI, 2'd0, 8'h04, "R6 low blocked without global-B");
    wr(2'd3, 8'h06);
    expect_out(1'b1, V_LO, 2'd3, 8'h06, "R5 low vector");
    wr(2'd3, 8'h07);
    take();
    expect_out(1'b0, V_LO, 2'd3, 8'h05, "R7 low take clears global-B");
    pulse_evt(8'h08);
    expect_out(1'b1, V_HI, 2'd0, 8'h0C, "R7 high preempts low handler");
    take();
    expect_out(1'b0, V_HI, 2'd3, 8'h04, "R7 high take clears global-A");
    wr(2'd0, 8'h04);
    ret();
    expect_out(1'b0, V_HI, 2'd3, 8'h05, "R9 return to low handler");
    ret();
    expect_out(1'b1, V_LO, 2'd3, 8'h07, "R9 low return re-enables and re-enters");

    // R8 low blocked during high handler
    wr(2'd0, 8'h00);
    expect_out(1'b0, V_HI, 2'd0, 8'h00, "R9 idle after flag clear");
    pulse_evt(8'h08);
    expect_out(1'b1, V_HI, 2'd3, 8'h07, "R5 high vector");
    take();
    pulse_evt(8'h04);
    expect_out(1'b0, V_HI, 2'd3, 8'h06, "R8 low held off during high handler");
    wr(2'd0, 8'h00);
    ret();
    expect_out(1'b0, V_HI, 2'd3, 8'h07, "R9 high return sets global-A");
    pulse_evt(8'h0C);
    expect_out(1'b1, V_HI, 2'd0, 8'h0C, "R5 high wins over low");
    expect_out(1'b1, V_HI, 2'd2, 8'h08, "R11 priority readback");
    expect_out(1'b1, V_HI, 2'd1, 8'h0C, "R11 enable readback");

    done = 1'b1;
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule